// File: doc/BRIEF.md
# Pixel Hit Recorder

This block is the digital back end of one detector pixel. It watches a discriminator level, sampled on the 40 MHz system clock, and turns each hit into a 28-bit result word. A shared 14-bit timestamp bus and a 4-bit phase count from a fast oscillator enter as inputs. A 2-bit mode input selects one of three ways to use the same 28 bits. In the two timing modes the pixel records when the pulse arrived, as a coarse stamp plus a fine phase, and optionally how many clock cycles the pulse stayed above threshold. In the counting mode it counts pulses, and accumulates the cycles spent above threshold, for as long as a shutter input is open.

The result stays on the output with a valid flag until the reader acknowledges it. From the first edge of a measurement until that acknowledge the pixel reports busy. In the timing modes no result is offered before a fixed settling window of clock cycles has passed since the hit. A mask input makes the pixel blind to its discriminator.

Top module: `pixel_hit_recorder`

## Requirements
- R1: After reset, `busy`, `data_valid` and `data_out` are all zero.
- R2: In a timing mode (`mode_in[1]`=0), a rising discriminator level seen on a clock edge while idle and unmasked is a hit. That edge's `stamp_in` goes to `data_out[27:14]` and its `phase_in` to `data_out[13:10]`, and `busy` is high from the next cycle.
- R3: In mode 2'b00, `data_out[9:0]` holds the number of clock edges on which the discriminator was high, counted from the hit edge up to the first edge on which it is low. The value saturates at 1023. Pulses that come later in the same measurement add nothing.
- R4: In mode 2'b01, `data_out[9:0]` is zero.
- R5: In the timing modes, `data_valid` rises on the 19th clock edge after the hit edge. In mode 2'b00, if the discriminator is still high then, it rises instead on the first edge that sees it low.
- R6: While busy in a timing mode, new discriminator edges neither restart the measurement nor change the stamp, the phase or the over-threshold count.
- R7: While `data_valid` is high and `read_ack` is low, `data_out` holds its value. An edge with `read_ack` high clears `data_valid` and `busy` for the next cycle. `data_out` is zero whenever `data_valid` is low.
- R8: While `mask_in` is high, discriminator activity starts no measurement and changes no result.
- R9: When `mode_in[1]`=1, the rising edge of `shutter_in` while idle clears both counters and sets `busy`. While the shutter is open, `data_out[9:0]` counts discriminator rising edges (saturating at 1023) and `data_out[23:10]` counts edges with the discriminator high (saturating at 16383). `data_out[27:24]` is zero. Pulses while the pixel is idle are not counted.
- R10: In counting mode, the first edge that sees the shutter closed sets `data_valid` for the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc_in | input | 1 | Discriminator level, synchronous to clk |
| mask_in | input | 1 | Blinds the pixel to disc_in |
| shutter_in | input | 1 | Counting window, used in counting mode |
| mode_in | input | 2 | 00 arrival+over-threshold, 01 arrival only, 1x counting |
| stamp_in | input | 14 | Global coarse timestamp |
| phase_in | input | 4 | Fine phase of the fast clock |
| read_ack | input | 1 | Reader takes the current result |
| data_out | output | 28 | Result word, zero when not valid |
| data_valid | output | 1 | Result word is ready |
| busy | output | 1 | Measurement or unread result in progress |

## Verification
The hit edge is edge zero. `busy` shows after edge zero, and the timing result after edge 19. For long pulses in mode 00 it shows after the first low edge instead. The bench measures this latency by counting falling edges from the hit, and compares the count with the larger of 19 and the pulse length. In counting mode the result appears one cycle after the shutter-close edge. An acknowledge takes effect in the next cycle. All inputs change and all outputs are read at falling edges, half a period away from the edges where the design updates.

// File: rtl/pixrec_pkg.sv
// Shared types for the pixel hit recorder.
// Assumes two mode-select bits; bit 1 picks counting.
package pixrec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MEAS  = 2'd1,
        ST_COUNT = 2'd2,
        ST_READY = 2'd3
    } pix_state_e;

    typedef enum logic [1:0] {
        MODE_TIME_CHARGE = 2'b00,
        MODE_TIME_ONLY   = 2'b01,
        MODE_COUNT       = 2'b10,
        MODE_COUNT_ALT   = 2'b11
    } pix_mode_e;

endpackage

// File: rtl/pixrec_edge.sv
// Registered rising-edge detector for a group of synchronous levels.
// Assumes the inputs are already synchronous to clk.
module pixrec_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    // Remember the previous sampled level of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        // One bit rises when it is high now and was low one edge before.
        assign rise[i] = lvl[i] & ~lvl_q[i];
    end
endmodule

// File: rtl/pixrec_sat_cnt.sv
// Saturating up-counter with a synchronous clear.
// Clear and increment on the same edge load the value one.
module pixrec_sat_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    // Count up, stop at all-ones, and restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               q <= '0;
        else if (clr)             q <= inc ? W'(1) : '0;
        else if (inc && q != TOP) q <= q + W'(1);
    end
endmodule

// File: rtl/pixrec_ctrl.sv
// Sequencer of the pixel. It accepts hits or a shutter window,
// enforces the settling window and holds the result until it is read.
// Assumes the mode inputs stay stable while busy; the format is latched at start.
module pixrec_ctrl
    import pixrec_pkg::*;
#(
    parameter int READY_DLY = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_mode,
    input  logic       tot_mode,
    input  logic       disc_lvl,
    input  logic       disc_rise,
    input  logic       shut_lvl,
    input  logic       shut_rise,
    input  logic       read_ack,
    output pix_state_e state,
    output logic       hit_take,
    output logic       open_take,
    output logic       tot_inc,
    output logic       cnt_inc,
    output logic       itot_inc,
    output logic       fmt_cnt,
    output logic       fmt_tot
);
    localparam int             WIN_W    = $clog2(READY_DLY + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(READY_DLY - 1);

    logic [WIN_W-1:0] win_q;
    logic             tot_done_q;

    // Start conditions and counter enables.
    always_comb begin
        hit_take  = (state == ST_IDLE) && !cnt_mode && disc_rise;
        open_take = (state == ST_IDLE) && cnt_mode && shut_rise;
        tot_inc   = disc_lvl && ((hit_take && tot_mode) ||
                    (state == ST_MEAS && fmt_tot && !tot_done_q));
        cnt_inc   = (state == ST_COUNT) && shut_lvl && disc_rise;
        itot_inc  = (state == ST_COUNT) && shut_lvl && disc_lvl;
    end

    // State, settling window and the latched result format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            win_q      <= '0;
            tot_done_q <= 1'b0;
            fmt_cnt    <= 1'b0;
            fmt_tot    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (open_take) begin
                        state   <= ST_COUNT;
                        fmt_cnt <= 1'b1;
                        fmt_tot <= 1'b0;
                    end else if (hit_take) begin
                        state      <= ST_MEAS;
                        win_q      <= '0;
                        tot_done_q <= 1'b0;
                        fmt_cnt    <= 1'b0;
                        fmt_tot    <= tot_mode;
                    end
                end
                ST_MEAS: begin
                    if (win_q != WIN_LAST) win_q <= win_q + WIN_W'(1);
                    if (!disc_lvl)         tot_done_q <= 1'b1;
                    if (win_q == WIN_LAST && (!fmt_tot || tot_done_q || !disc_lvl))
                        state <= ST_READY;
                end
                ST_COUNT: begin
                    if (!shut_lvl) state <= ST_READY;
                end
                ST_READY: begin
                    if (read_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pixel_hit_recorder.sv
// Top of the pixel back end. It puts the timestamp latch, the three counters
// and the sequencer together and lays out the 28-bit result for each mode.
// Assumes disc_in, shutter_in and mode_in are synchronous to clk.
module pixel_hit_recorder
    import pixrec_pkg::*;
#(
    parameter int TIME_W    = 14,
    parameter int FINE_W    = 4,
    parameter int TOT_W     = 10,
    parameter int ITOT_W    = 14,
    parameter int CNT_W     = 10,
    parameter int READY_DLY = 19,
    localparam int DATA_W   = TIME_W + FINE_W + TOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disc_in,
    input  logic              mask_in,
    input  logic              shutter_in,
    input  logic [1:0]        mode_in,
    input  logic [TIME_W-1:0] stamp_in,
    input  logic [FINE_W-1:0] phase_in,
    input  logic              read_ack,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              busy
);
    logic              disc_eff;
    logic [1:0]        rises;
    pix_state_e        state;
    logic              hit_take, open_take, tot_inc, cnt_inc, itot_inc;
    logic              fmt_cnt, fmt_tot;
    logic [TIME_W-1:0] stamp_q;
    logic [FINE_W-1:0] phase_q;
    logic [TOT_W-1:0]  tot_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ITOT_W-1:0] itot_q;
    logic [DATA_W-1:0] word_time, word_cnt;

    // A masked pixel sees a permanently low discriminator.
    assign disc_eff = disc_in & ~mask_in;

    pixrec_edge #(.N(2)) u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .lvl ({shutter_in, disc_eff}),
        .rise (rises)
    );

    pixrec_ctrl #(.READY_DLY(READY_DLY)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_mode  (mode_in[1]),
        .tot_mode  (mode_in == MODE_TIME_CHARGE),
        .disc_lvl  (disc_eff),
        .disc_rise (rises[0]),
        .shut_lvl  (shutter_in),
        .shut_rise (rises[1]),
        .read_ack  (read_ack),
        .state     (state),
        .hit_take  (hit_take),
        .open_take (open_take),
        .tot_inc   (tot_inc),
        .cnt_inc   (cnt_inc),
        .itot_inc  (itot_inc),
        .fmt_cnt   (fmt_cnt),
        .fmt_tot   (fmt_tot)
    );

    // Capture the coarse stamp and fine phase on the accepted hit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
            phase_q <= '0;
        end else if (hit_take) begin
            stamp_q <= stamp_in;
            phase_q <= phase_in;
        end
    end

    pixrec_sat_cnt #(.W(TOT_W)) u_tot (
        .clk (clk), .rst_n (rst_n), .clr (hit_take), .inc (tot_inc), .q (tot_q)
    );

    pixrec_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk (clk), .rst_n (rst_n), .clr (open_take), .inc (cnt_inc), .q (cnt_q)
    );

    pixrec_sat_cnt #(.W(ITOT_W)) u_itot (
        .clk (clk), .rst_n (rst_n), .clr (open_take), .inc (itot_inc), .q (itot_q)
    );

    // Lay out both result formats and present the one that was latched.
    always_comb begin
        word_time  = {stamp_q, phase_q, fmt_tot ? tot_q : {TOT_W{1'b0}}};
        word_cnt   = DATA_W'({itot_q, cnt_q});
        data_valid = (state == ST_READY);
        busy       = (state != ST_IDLE);
        data_out   = data_valid ? (fmt_cnt ? word_cnt : word_time) : '0;
    end
endmodule

// File: rtl/pixrec_checker.sv
// Protocol checker for the pixel hit recorder, attached with bind.
// Assumes it sees only the ports of the top module.
module pixrec_checker #(
    parameter int READY_DLY = 19,
    parameter int DATA_W    = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disc_in,
    input logic              mask_in,
    input logic              mode_hi,
    input logic              read_ack,
    input logic [DATA_W-1:0] data_out,
    input logic              data_valid,
    input logic              busy
);
    localparam int CW = $clog2(READY_DLY + 1);
    logic [CW-1:0] busy_cnt;

    // Count the cycles of the current busy period, saturating at the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)                  busy_cnt <= '0;
        else if (busy_cnt != CW'(READY_DLY)) busy_cnt <= busy_cnt + CW'(1);
    end

    assert_hit_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mode_hi && !mask_in && disc_in && !$past(disc_in)) |=> busy);

    assert_window_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_valid) && !mode_hi) |-> (busy_cnt == CW'(READY_DLY)));

    assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !read_ack) |=> (data_valid && $stable(data_out)));

    assert_ack_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && read_ack) |=> (!data_valid && !busy));

    assert_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (data_out == '0));

    assert_valid_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> busy);

    assert_mask_blinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mask_in && !mode_hi) |=> !busy);
endmodule

bind pixel_hit_recorder pixrec_checker #(.READY_DLY(READY_DLY), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disc_in    (disc_in),
    .mask_in    (mask_in),
    .mode_hi    (mode_in[1]),
    .read_ack   (read_ack),
    .data_out   (data_out),
    .data_valid (data_valid),
    .busy       (busy)
);

// File: tb/tb_pixel_hit_recorder.sv
module tb_pixel_hit_recorder;
    localparam int CLK_PERIOD = 25;
    localparam int DLY        = 19;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 7;
    // {mode[1:0], stamp[13:0], phase[3:0], pulse length[10:0]}
    localparam logic [30:0] VECS [0:NVEC-1] = '{
        {2'd0, 14'd100,   4'd7,  11'd4},
        {2'd0, 14'd16383, 4'd15, 11'd1},
        {2'd1, 14'd0,     4'd0,  11'd5},
        {2'd0, 14'd5000,  4'd3,  11'd30},
        {2'd1, 14'd12345, 4'd9,  11'd40},
        {2'd0, 14'd1,     4'd0,  11'd19},
        {2'd0, 14'd8191,  4'd12, 11'd1030}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disc_in = 1'b0, mask_in = 1'b0, shutter_in = 1'b0, read_ack = 1'b0;
    logic [1:0]  mode_in = 2'd0;
    logic [13:0] stamp_in = '0;
    logic [3:0]  phase_in = '0;
    logic [27:0] data_out;
    logic        data_valid, busy;
    int          n_chk = 0, n_err = 0;

    pixel_hit_recorder dut (
        .clk (clk), .rst_n (rst_n), .disc_in (disc_in), .mask_in (mask_in),
        .shutter_in (shutter_in), .mode_in (mode_in), .stamp_in (stamp_in),
        .phase_in (phase_in), .read_ack (read_ack), .data_out (data_out),
        .data_valid (data_valid), .busy (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_and_check(input string req);
        read_ack = 1'b1;
        tick(1);
        read_ack = 1'b0;
        chk(req, "valid after ack", {31'd0, data_valid}, 32'd0);
        chk(req, "busy after ack", {31'd0, busy}, 32'd0);
        chk(req, "data after ack", {4'd0, data_out}, 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "valid", {31'd0, data_valid}, 32'd0);
        chk("R1", "data", {4'd0, data_out}, 32'd0);
        rst_n = 1'b1;
        tick(2);

        // Vector walk: R2, R3, R4, R5 in both timing modes.
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  m;
            logic [13:0] st;
            logic [3:0]  ph;
            int          len, lat, exp_lat, exp_tot, lim;
            m   = VECS[v][30:29];
            st  = VECS[v][28:15];
            ph  = VECS[v][14:11];
            len = int'(VECS[v][10:0]);
            exp_tot = (m == 2'd0) ? ((len > 1023) ? 1023 : len) : 0;
            exp_lat = (m == 2'd0 && len > DLY) ? len : DLY;
            lim = ((len > DLY) ? len : DLY) + 3;
            lat = -1;
            mode_in = m; stamp_in = st; phase_in = ph; disc_in = 1'b1;
            for (int c = 1; c <= lim; c++) begin
                tick(1);
                stamp_in = stamp_in + 14'd1;
                if (c == 1) chk("R2", "busy after hit", {31'd0, busy}, 32'd1);
                if (c == len) disc_in = 1'b0;
                if (lat < 0 && data_valid) lat = c - 1;
            end
            chk("R5", "latency", lat, exp_lat);
            chk("R2", "stamp", {18'd0, data_out[27:14]}, {18'd0, st});
            chk("R2", "phase", {28'd0, data_out[13:10]}, {28'd0, ph});
            if (m == 2'd0) chk("R3", "over-threshold", {22'd0, data_out[9:0]}, exp_tot);
            else           chk("R4", "unused field", {22'd0, data_out[9:0]}, 32'd0);
            ack_and_check("R7");
            tick(1);
        end

        // R6: second pulse during measurement and a pulse while ready.
        mode_in = 2'd0; stamp_in = 14'd200; phase_in = 4'd5; disc_in = 1'b1;
        tick(3); disc_in = 1'b0;
        tick(2); stamp_in = 14'd999; phase_in = 4'd1; disc_in = 1'b1;
        tick(3); disc_in = 1'b0;
        tick(11);
        chk("R5", "not ready before window", {31'd0, data_valid}, 32'd0);
        tick(1);
        chk("R5", "ready at window", {31'd0, data_valid}, 32'd1);
        chk("R6", "result kept", {4'd0, data_out}, {4'd0, 14'd200, 4'd5, 10'd3});
        stamp_in = 14'd777; disc_in = 1'b1;
        tick(2); disc_in = 1'b0;
        tick(2);
        chk("R7", "held while ready", {4'd0, data_out}, {4'd0, 14'd200, 4'd5, 10'd3});
        ack_and_check("R6");
        tick(3);
        chk("R6", "no restart from old pulse", {31'd0, busy}, 32'd0);

        // R8: masked pulses start nothing.
        begin
            int seen_busy;
            seen_busy = 0;
            mask_in = 1'b1; disc_in = 1'b1;
            for (int c = 0; c < 25; c++) begin
                tick(1);
                if (c == 3) disc_in = 1'b0;
                if (c == 8) disc_in = 1'b1;
                if (c == 10) disc_in = 1'b0;
                if (busy) seen_busy = 1;
            end
            chk("R8", "busy while masked", seen_busy, 32'd0);
            chk("R8", "data while masked", {4'd0, data_out}, 32'd0);
            mask_in = 1'b0;
            tick(2);
        end

        // R9/R10: counting mode with pulses before and inside the shutter.
        mode_in = 2'd2;
        disc_in = 1'b1; tick(2); disc_in = 1'b0; tick(2);
        chk("R9", "idle pulse no busy", {31'd0, busy}, 32'd0);
        shutter_in = 1'b1; tick(1);
        chk("R9", "busy on open", {31'd0, busy}, 32'd1);
        for (int p = 0; p < 3; p++) begin
            disc_in = 1'b1; tick(4); disc_in = 1'b0; tick(1);
        end
        chk("R10", "not valid while open", {31'd0, data_valid}, 32'd0);
        shutter_in = 1'b0; tick(1);
        chk("R10", "valid after close", {31'd0, data_valid}, 32'd1);
        chk("R9", "count word", {4'd0, data_out}, {4'd0, 4'd0, 14'd12, 10'd3});
        ack_and_check("R10");

        // R9: pulse count saturation in mode 11.
        mode_in = 2'd3; shutter_in = 1'b1; tick(1);
        for (int p = 0; p < 1030; p++) begin
            disc_in = 1'b1; tick(1); disc_in = 1'b0; tick(1);
        end
        shutter_in = 1'b0; tick(1);
        chk("R9", "count saturates", {4'd0, data_out}, {4'd0, 4'd0, 14'd1030, 10'd1023});
        ack_and_check("R9");

        // R9: integrated over-threshold saturation.
        mode_in = 2'd2; shutter_in = 1'b1; tick(1);
        disc_in = 1'b1; tick(16400); disc_in = 1'b0; tick(1);
        shutter_in = 1'b0; tick(1);
        chk("R9", "integral saturates", {4'd0, data_out}, {4'd0, 4'd0, 14'd16383, 10'd1});
        ack_and_check("R9");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule